// File: doc/BRIEF.md
# Stereo Soft-Mute Volume Stage

This block scales a two-channel stream of signed audio samples by a gain picked from an 8-bit attenuation code. Code 255 is unity gain, each lower code is 0.5 dB quieter, and code 0 is silence. Samples arrive with a one-cycle strobe. Scaled samples leave two clocks later with a one-cycle valid pulse.

Muting never cuts the signal in one step. Either a mute pin or a mute control bit can start a mute. The working code then walks one step toward zero every 16 sample strobes, so a full ramp from 255 takes 4080 sample periods. When both mute sources go low, the code walks back up to the programmed level at the same rate, starting from wherever it is. A new programmed level is approached in the same way, so volume changes also ramp.

The gain for each code comes from an internal 256-entry table that is built when the design elaborates. The table is read through a registered port, so it can sit in block RAM.

Top module: `softmute_vol`

## Requirements
- R1: The gain for code c is 0 when c = 0. Otherwise it is round(32768 × 10^(-(255 − c)/40)), an unsigned value in which 32768 means unity. Code 255 therefore gives exactly 32768.
- R2: Each output is (sample × gain + 16384) shifted arithmetically right by 15 and saturated to 16-bit signed. The gain used is the one for the working code as it stood before that strobe's ramp step.
- R3: A mute is requested when mute_pin or mute_reg is 1. The ramp target is then code 0. When both are 0, the target is level_cfg.
- R4: The working code moves by exactly one toward the target on every 16th strobe while it differs from the target. A ramp from 255 reaches 0 on the 4080th strobe and not before.
- R5: A strobe that finds the working code equal to the target clears the step-phase counter. Without a strobe, the working code never changes.
- R6: If the mute is released before silence is reached, the code turns around and climbs from its current value at the same rate. The phase counter is not restarted.
- R7: A change of level_cfg while no mute is requested is reached by the same ramp of one code per 16 strobes.
- R8: at_silence is 1 exactly when the working code is 0.
- R9: Synchronous reset loads level_cfg as the working code and clears the phase counter. It also forces out_valid, left_out and right_out to 0.
- R10: out_valid goes high for one cycle, two clock edges after the edge that samples smp_stb. When there is no strobe, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one cycle per stereo sample |
| left_in | input | 16 | Left input sample, signed |
| right_in | input | 16 | Right input sample, signed |
| level_cfg | input | 8 | Programmed attenuation code (255 = 0 dB) |
| mute_pin | input | 1 | External mute request |
| mute_reg | input | 1 | Control-bit mute request |
| left_out | output | 16 | Scaled left sample, signed |
| right_out | output | 16 | Scaled right sample, signed |
| out_valid | output | 1 | One-cycle pulse marking new output samples |
| at_silence | output | 1 | Working code is 0 |

## Verification
The bench times the full ramp from 255. A step period that is off by one shows up as silence one strobe early or late around strobe 4080. It releases the mute after 100 strobes, partway through a step period. A design that restarts the phase or snaps back to the target then produces output samples scaled by the wrong code. It also drops one of two mute sources while the other stays set: a design that combines the sources with AND would start climbing. In a random phase that toggles both mute sources and the level, every output is compared with a bench model. The model covers the rounding of negative products, the extremes of the sample range, and whether the gain is sampled before or after the step.

// File: rtl/smr_pkg.sv
package smr_pkg;

  // Unsigned gain for a level code; code 'top' is unity (2**(gw-1)), each step below is -0.5 dB.
  function automatic int unsigned gain_code(int unsigned code, int unsigned top, int unsigned gw);
    real steps;
    real lin;
    if (code == 0) return 0;
    steps = real'(top - code);
    lin   = (2.0 ** (gw - 1)) * (10.0 ** (-steps / 40.0));
    return $rtoi(lin + 0.5);
  endfunction

endpackage

// File: rtl/smr_gain_rom.sv
module smr_gain_rom #(
  parameter int unsigned LW = 8,
  parameter int unsigned GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [LW-1:0] rd_addr,
  output logic [GW-1:0] gain
);
  localparam int unsigned LEVELS = 1 << LW;
  localparam int unsigned TOP    = LEVELS - 1;
  localparam logic [GW-1:0] UNITY = GW'(1) << (GW - 1);

  logic [GW-1:0] table_q [LEVELS];

  for (genvar i = 0; i < LEVELS; i++) begin : g_tab
    assign table_q[i] = GW'(smr_pkg::gain_code(i, TOP, GW));
  end

  always_ff @(posedge clk) begin
    if (rst)        gain <= '0;
    else if (rd_en) gain <= table_q[rd_addr];
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R1: top code reads back as exact unity, code 0 as zero gain
  a_r1_unity_top: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rd_en) && $past(rd_addr) == LW'(TOP)) |-> (gain == UNITY));
  a_r1_zero_code: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rd_en) && $past(rd_addr) == '0) |-> (gain == '0));
endmodule

// File: rtl/smr_level_ramp.sv
module smr_level_ramp #(
  parameter int unsigned LW       = 8,
  parameter int unsigned STEP_SMP = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          mute_req,
  input  logic [LW-1:0] level_cfg,
  output logic [LW-1:0] level_q
);
  localparam int unsigned CW = (STEP_SMP > 1) ? $clog2(STEP_SMP) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_SMP - 1);

  logic [LW-1:0] target;
  logic [CW-1:0] phase_q;

  assign target = mute_req ? '0 : level_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= level_cfg;
      phase_q <= '0;
    end else if (stb) begin
      if (level_q == target) begin
        phase_q <= '0;
      end else if (phase_q == LAST) begin
        phase_q <= '0;
        level_q <= (target > level_q) ? level_q + LW'(1) : level_q - LW'(1);
      end else begin
        phase_q <= phase_q + CW'(1);
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R4: the working code moves by at most one per clock
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst || !armed)
    ((LW+1)'(level_q) == (LW+1)'($past(level_q))) ||
    ((LW+1)'(level_q) == (LW+1)'($past(level_q)) + (LW+1)'(1)) ||
    ((LW+1)'(level_q) + (LW+1)'(1) == (LW+1)'($past(level_q))));
  // R5: no strobe, no movement
  a_r5_strobe_only: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(stb) |-> (level_q == $past(level_q)));
  // R3: any movement heads toward the target seen at that strobe
  a_r3_rise_dir: assert property (@(posedge clk) disable iff (rst || !armed)
    (level_q > $past(level_q)) |-> ($past(target) > $past(level_q)));
  a_r3_fall_dir: assert property (@(posedge clk) disable iff (rst || !armed)
    (level_q < $past(level_q)) |-> ($past(target) < $past(level_q)));
endmodule

// File: rtl/smr_gain_apply.sv
module smr_gain_apply #(
  parameter int unsigned DW = 16,
  parameter int unsigned GW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 fire,
  input  logic signed [DW-1:0] smp,
  input  logic        [GW-1:0] gain,
  output logic signed [DW-1:0] y
);
  localparam int unsigned PW = DW + GW + 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (GW - 2);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW - 1));

  logic signed [DW-1:0] smp_q;
  logic signed [PW-1:0] prod, rnd, sat;

  always_ff @(posedge clk) begin
    if (rst)       smp_q <= '0;
    else if (load) smp_q <= smp;
  end

  always_comb begin
    prod = PW'(smp_q) * PW'($signed({1'b0, gain}));
    rnd  = (prod + RND) >>> (GW - 1);
    if (rnd > MAXV)      sat = MAXV;
    else if (rnd < MINV) sat = MINV;
    else                 sat = rnd;
  end

  always_ff @(posedge clk) begin
    if (rst)       y <= '0;
    else if (fire) y <= DW'(sat);
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R2: output magnitude never exceeds the input magnitude (gain <= unity)
  a_r2_no_gain: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(fire) |-> (((y < 0) ? -(DW+1)'(y) : (DW+1)'(y)) <=
                     (($past(smp_q) < 0) ? -(DW+1)'($past(smp_q)) : (DW+1)'($past(smp_q)))));
  // R1: zero gain yields exact zero
  a_r1_zero_out: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(fire) && $past(gain) == '0) |-> (y == '0));
  // R10: output holds without a fire
  a_r10_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(fire) |-> $stable(y));
endmodule

// File: rtl/softmute_vol.sv
module softmute_vol #(
  parameter int unsigned DW       = 16,
  parameter int unsigned LW       = 8,
  parameter int unsigned GW       = 16,
  parameter int unsigned STEP_SMP = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] left_in,
  input  logic signed [DW-1:0] right_in,
  input  logic        [LW-1:0] level_cfg,
  input  logic                 mute_pin,
  input  logic                 mute_reg,
  output logic signed [DW-1:0] left_out,
  output logic signed [DW-1:0] right_out,
  output logic                 out_valid,
  output logic                 at_silence
);
  localparam int unsigned NCH = 2;

  logic          mute_req;
  logic [LW-1:0] level_q;
  logic [GW-1:0] gain_q;
  logic          v1_q;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];

  assign mute_req  = mute_pin | mute_reg;
  assign ch_in[0]  = left_in;
  assign ch_in[1]  = right_in;
  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];
  assign at_silence = (level_q == '0);

  smr_level_ramp #(.LW(LW), .STEP_SMP(STEP_SMP)) u_ramp (
    .clk(clk), .rst(rst), .stb(smp_stb), .mute_req(mute_req),
    .level_cfg(level_cfg), .level_q(level_q)
  );

  smr_gain_rom #(.LW(LW), .GW(GW)) u_rom (
    .clk(clk), .rst(rst), .rd_en(smp_stb), .rd_addr(level_q), .gain(gain_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= smp_stb;
      out_valid <= v1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smr_gain_apply #(.DW(DW), .GW(GW)) u_apply (
      .clk(clk), .rst(rst), .load(smp_stb), .fire(v1_q),
      .smp(ch_in[c]), .gain(gain_q), .y(ch_out[c])
    );
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R10: a valid pulse always traces back to a strobe two edges earlier
  a_r10_valid_src: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |-> $past(smp_stb, 2));
  // R3: while muted the working code never rises
  a_r3_mute_no_rise: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(mute_req) && $past(smp_stb)) |-> (level_q <= $past(level_q)));
endmodule

// File: tb/softmute_vol_bench.sv
`timescale 1ns/1ps
module softmute_vol_bench;
  logic clk = 1'b0;
  logic rst, smp_stb, mute_pin, mute_reg;
  logic signed [15:0] left_in, right_in, left_out, right_out;
  logic [7:0] level_cfg;
  logic out_valid, at_silence;

  int checks = 0;
  int errors = 0;
  int m_cur, m_cnt;
  bit done = 0;

  always #2 clk = ~clk;

  softmute_vol u_softmute_vol (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .left_in(left_in), .right_in(right_in),
    .level_cfg(level_cfg), .mute_pin(mute_pin), .mute_reg(mute_reg),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid), .at_silence(at_silence)
  );

  function automatic longint gain_ref(int code);
    if (code == 0) return 0;
    return longint'($rtoi(32768.0 * (10.0 ** (-(real'(255 - code)) / 40.0)) + 0.5));
  endfunction

  function automatic int exp_out(int s, int code);
    longint p, r;
    p = longint'(s) * gain_ref(code);
    r = (p + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic model_step();
    int tgt;
    tgt = (mute_pin || mute_reg) ? 0 : int'(level_cfg);
    if (m_cur == tgt) m_cnt = 0;
    else if (m_cnt == 15) begin
      m_cnt = 0;
      m_cur = (tgt > m_cur) ? m_cur + 1 : m_cur - 1;
    end else m_cnt++;
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  // called at a negedge; returns at a negedge
  task automatic do_sample(int l, int r, string tag);
    int el, er;
    el = exp_out(l, m_cur);
    er = exp_out(r, m_cur);
    model_step();
    left_in = 16'(l); right_in = 16'(r); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, {tag, " R10 valid"}, out_valid, 1);
    chk(int'(left_out) == el, {tag, " R2 left"}, left_out, el);
    chk(int'(right_out) == er, {tag, " R2 right"}, right_out, er);
    chk(at_silence == (m_cur == 0), {tag, " R8 silence"}, at_silence, m_cur == 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1; smp_stb = 0; mute_pin = 0; mute_reg = 0; level_cfg = 8'd255;
    left_in = 0; right_in = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    m_cur = 255; m_cnt = 0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 0, "R9 valid", out_valid, 0);
    chk(left_out == 0 && right_out == 0, "R9 outputs", left_out, 0);
    chk(at_silence == 0, "R9 level loaded", at_silence, 0);

    // R1/R2 unity and extremes
    do_sample(32767, -32768, "R1 unity extremes");
    do_sample(-1, 1, "R1 unity small");
    for (int i = 0; i < 20; i++) do_sample(rnd16(), rnd16(), "R2 unity random");

    // R10 idle: outputs hold, no valid
    begin
      logic signed [15:0] hl;
      hl = left_out;
      for (int i = 0; i < 5; i++) begin
        left_in = 16'(rnd16());
        @(negedge clk);
        chk(out_valid == 0, "R10 idle valid", out_valid, 0);
        chk(left_out == hl, "R10 idle hold", left_out, hl);
      end
    end

    // R7 level change without mute
    level_cfg = 8'd200;
    for (int i = 0; i < 16 * 55 + 4; i++) do_sample(rnd16(), rnd16(), "R7 level ramp");
    chk(m_cur == 200, "R7 model settled", m_cur, 200);

    // R3 mute via pin, ramp to silence
    mute_pin = 1;
    for (int i = 0; i < 16 * 200 + 4; i++) do_sample(rnd16(), rnd16(), "R3 pin mute");
    chk(at_silence == 1, "R3 silent", at_silence, 1);
    // R3 release needs both low
    mute_reg = 1; mute_pin = 0;
    for (int i = 0; i < 40; i++) do_sample(rnd16(), rnd16(), "R3 reg holds mute");
    chk(at_silence == 1, "R3 still silent", at_silence, 1);
    mute_reg = 0;
    for (int i = 0; i < 16 * 200 + 4; i++) do_sample(rnd16(), rnd16(), "R3 release climb");

    // R4 full ramp timing from 255
    level_cfg = 8'd255;
    for (int i = 0; i < 16 * 55 + 4; i++) do_sample(rnd16(), rnd16(), "R4 to top");
    mute_reg = 1;
    for (int i = 1; i <= 4081; i++) begin
      do_sample(rnd16(), rnd16(), "R4 full ramp");
      if (i == 4079) chk(at_silence == 0, "R4 not yet silent at 4079", at_silence, 0);
      if (i == 4080) chk(at_silence == 1, "R4 silent at 4080", at_silence, 1);
    end
    mute_reg = 0;
    for (int i = 0; i < 4090; i++) do_sample(rnd16(), rnd16(), "R4 climb back");

    // R6 release mid-ramp (phase mid-period)
    mute_pin = 1;
    for (int i = 0; i < 100; i++) do_sample(rnd16(), rnd16(), "R6 partial mute");
    mute_pin = 0;
    for (int i = 0; i < 120; i++) do_sample(rnd16(), rnd16(), "R6 reverse");

    // R5 phase clears when at target
    mute_pin = 1;
    for (int i = 0; i < 10; i++) do_sample(rnd16(), rnd16(), "R5 short mute");
    mute_pin = 0;
    do_sample(rnd16(), rnd16(), "R5 at target");
    mute_pin = 1;
    for (int i = 0; i < 40; i++) do_sample(rnd16(), rnd16(), "R5 fresh phase");
    mute_pin = 0;
    for (int i = 0; i < 60; i++) do_sample(rnd16(), rnd16(), "R5 recover");

    // random mix
    for (int i = 0; i < 2500; i++) begin
      if ($urandom_range(99) < 2) mute_pin = ~mute_pin;
      if ($urandom_range(99) < 2) mute_reg = ~mute_reg;
      if ($urandom_range(99) < 1) level_cfg = 8'($urandom);
      do_sample(rnd16(), rnd16(), "R7 random mix");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule